// File: doc/BRIEF.md
# Warp Lane-Mask Sequencer

This block steers one warp of lanes that run in lockstep from a single shared instruction stream. Each cycle an outside decoder presents one instruction, a per-lane condition vector, and for branches a target and a merge address. The block returns the per-lane register write enables for that instruction and advances the shared program counter. Lanes switched off in the active mask still see the broadcast instruction, but their write enable stays low, so for them it acts as a no-op.

A compare sets a one-bit predicate in each active lane. A later predicated instruction commits only where that bit is set, and no branch is involved. A conditional branch on which the active lanes disagree is split. The lanes that take it run the target path first. A stack entry records the merge address, the fall-through address, the fall-through lanes and the mask from before the split. When the counter reaches the merge address, the block spends one switch cycle moving to the waiting path. A second switch cycle at the same address pops the entry and restores the earlier mask. Every executed cycle with only part of the warp enabled is counted, so the cost of divergence can be measured.

Top module: `warp_lane_ctrl`

## Requirements
- R1: After synchronous reset the program counter equals START_PC, all lanes are active, every predicate bit is clear, the stack depth is zero, the error flag is low and the partial-mask counter is zero.
- R2: An executed ALU instruction (opcode 2'b00) raises the write enable of exactly the active lanes and advances the program counter by one.
- R3: An executed compare (opcode 2'b10) copies the condition bit into the predicate of each active lane, leaves the predicate of inactive lanes unchanged, raises no write enable and advances the program counter by one.
- R4: An executed predicated instruction (opcode 2'b01) raises the write enable only in lanes that are both active and predicated, and advances the program counter by one.
- R5: A branch (opcode 2'b11) on which all active lanes agree leaves the mask and stack depth unchanged. It loads the target when all active lanes take it and advances by one when none take it. Conditions of inactive lanes are ignored.
- R6: A branch that splits the active lanes raises no write enable, pushes one stack entry, loads the target, and narrows the mask to the active lanes whose condition is set.
- R7: When the stack is not empty and the program counter equals the merge address on top, and the fall-through path has not yet run, that cycle is a switch cycle. The presented instruction is ignored with all write enables low, the mask becomes the fall-through lanes and the program counter becomes the branch address plus one.
- R8: At the merge address on top with the fall-through path already run, the switch cycle pops the entry, restores the mask held before the split and keeps the program counter.
- R9: The partial-mask counter increases by one on each executed, non-switch cycle in which the mask is not all ones, and saturates at its maximum.
- R10: A split branch with the stack already full sets a sticky error flag, leaves the depth unchanged and still narrows the mask to the taking lanes.
- R11: With instr_valid low and no switch pending, the write enables stay low and the program counter, mask and predicates keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_op | input | 2 | Opcode: 00 ALU, 01 predicated ALU, 10 compare, 11 branch |
| lane_cond | input | LANES | Per-lane condition result |
| br_target | input | PC_W | Branch target address |
| br_reconv | input | PC_W | Merge address for a split branch |
| lane_we | output | LANES | Per-lane register write enable |
| pc | output | PC_W | Shared program counter of the presented instruction |
| active_mask | output | LANES | Current active-lane mask |
| pred_mask | output | LANES | Per-lane predicate bits |
| stack_depth | output | $clog2(STACK_DEPTH+1) | Entries on the merge stack |
| div_cycles | output | CNT_W | Executed cycles with a partial mask |
| stack_err | output | 1 | Sticky stack overflow flag |

## Verification
The program drives branches that every lane takes, that no lane takes, and that split the warp. These separate a plain jump, a fall-through and a pushed divergence. A nested split whose outer path jumps straight to the inner merge address covers two switch cycles in a row at one address, once to change path and once to pop. The same run shows whether the merge uses the waiting mask or the saved one. Compares issued under a partial mask show whether inactive lanes keep their predicate. Nine nested splits check the stack overflow behaviour, and a mid-run reset checks that all state returns to its starting values.

// File: rtl/warp_pkg.sv
// Package: opcode and branch-outcome encodings shared by the warp sequencer.
package warp_pkg;

    typedef enum logic [1:0] {
        OP_ALU  = 2'b00,
        OP_PALU = 2'b01,
        OP_CMP  = 2'b10,
        OP_BRA  = 2'b11
    } warp_op_e;

    typedef enum logic [1:0] {
        BR_NONE  = 2'b00,
        BR_TAKE  = 2'b01,
        BR_FALL  = 2'b10,
        BR_SPLIT = 2'b11
    } br_kind_e;

endpackage

// File: rtl/warp_lane_enable.sv
// Module: per-lane write-enable decode and branch classification.
// Assumes the active mask is never empty while an instruction executes.
// Purely combinational; exec gates every output to its idle value.
module warp_lane_enable
    import warp_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             exec,
    input  warp_op_e         op,
    input  logic [LANES-1:0] act,
    input  logic [LANES-1:0] pred,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] we,
    output logic [LANES-1:0] take_lanes,
    output logic [LANES-1:0] fall_lanes,
    output br_kind_e         kind
);

    // Purpose: split active lanes by condition, then decode enables and branch outcome.
    always_comb begin
        take_lanes = cond & act;
        fall_lanes = act & ~cond;
        we         = '0;
        kind       = BR_NONE;
        if (exec) begin
            unique case (op)
                OP_ALU:  we = act;
                OP_PALU: we = act & pred;
                OP_CMP:  we = '0;
                OP_BRA: begin
                    if (fall_lanes == '0)      kind = BR_TAKE;
                    else if (take_lanes == '0) kind = BR_FALL;
                    else                       kind = BR_SPLIT;
                end
                default: we = '0;
            endcase
        end
    end

endmodule

// File: rtl/warp_reconv_stack.sv
// Module: merge stack holding, per split branch, the merge address, the
// waiting path address and lanes, the saved mask and a waiting flag.
// Assumes push and pop are never requested in the same cycle.
// A push while full is dropped and flagged through ovf.
module warp_reconv_stack #(
    parameter int DEPTH = 8,
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             take_pend,
    input  logic [PC_W-1:0]  in_rcv,
    input  logic [PC_W-1:0]  in_pend_pc,
    input  logic [LANES-1:0] in_pend_mask,
    input  logic [LANES-1:0] in_save_mask,
    output logic [PC_W-1:0]  top_rcv,
    output logic [PC_W-1:0]  top_pend_pc,
    output logic [LANES-1:0] top_pend_mask,
    output logic [LANES-1:0] top_save_mask,
    output logic             top_pend_vld,
    output logic [CW-1:0]    depth,
    output logic             empty,
    output logic             full,
    output logic             ovf
);

    logic [CW-1:0]    depth_q;
    logic [IW-1:0]    top_idx;
    logic [PC_W-1:0]  rcv_w       [DEPTH];
    logic [PC_W-1:0]  pend_pc_w   [DEPTH];
    logic [LANES-1:0] pend_mask_w [DEPTH];
    logic [LANES-1:0] save_mask_w [DEPTH];
    logic [DEPTH-1:0] pend_vld_w;

    assign empty   = (depth_q == '0);
    assign full    = (depth_q == CW'(DEPTH));
    assign ovf     = push && full;
    assign depth   = depth_q;
    assign top_idx = IW'(depth_q - CW'(1));

    // Purpose: one storage slot per stack level, written on push at its level.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [PC_W-1:0]  rcv_r;
        logic [PC_W-1:0]  pend_pc_r;
        logic [LANES-1:0] pend_mask_r;
        logic [LANES-1:0] save_mask_r;
        logic             pend_vld_r;

        // Purpose: capture an entry on push; drop its waiting flag once that path starts.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rcv_r       <= '0;
                pend_pc_r   <= '0;
                pend_mask_r <= '0;
                save_mask_r <= '0;
                pend_vld_r  <= 1'b0;
            end else if (push && !full && depth_q == CW'(g)) begin
                rcv_r       <= in_rcv;
                pend_pc_r   <= in_pend_pc;
                pend_mask_r <= in_pend_mask;
                save_mask_r <= in_save_mask;
                pend_vld_r  <= 1'b1;
            end else if (take_pend && !empty && top_idx == IW'(g)) begin
                pend_vld_r  <= 1'b0;
            end
        end

        assign rcv_w[g]       = rcv_r;
        assign pend_pc_w[g]   = pend_pc_r;
        assign pend_mask_w[g] = pend_mask_r;
        assign save_mask_w[g] = save_mask_r;
        assign pend_vld_w[g]  = pend_vld_r;
    end

    // Purpose: present the top entry; an empty stack shows zeros.
    always_comb begin
        top_rcv       = '0;
        top_pend_pc   = '0;
        top_pend_mask = '0;
        top_save_mask = '0;
        top_pend_vld  = 1'b0;
        if (!empty) begin
            top_rcv       = rcv_w[top_idx];
            top_pend_pc   = pend_pc_w[top_idx];
            top_pend_mask = pend_mask_w[top_idx];
            top_save_mask = save_mask_w[top_idx];
            top_pend_vld  = pend_vld_w[top_idx];
        end
    end

    // Purpose: track the number of live entries.
    always_ff @(posedge clk) begin
        if (!rst_n)                 depth_q <= '0;
        else if (push && !full)     depth_q <= depth_q + CW'(1);
        else if (pop && !empty)     depth_q <= depth_q - CW'(1);
    end

endmodule

// File: rtl/warp_div_counter.sv
// Module: saturating counter of executed cycles run with a partial lane mask.
// Assumes inc is already qualified by the caller.
module warp_div_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_q;

    // Purpose: count up on inc and hold at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (inc && cnt_q != '1) cnt_q <= cnt_q + W'(1);
    end

    assign count = cnt_q;

endmodule

// File: rtl/warp_lane_ctrl.sv
// Module: lockstep mask and program-counter sequencer for one warp.
// Holds the active mask, the predicates and the shared PC. Split branches run
// the taken lanes first, then the fall-through lanes, and merge back through a
// stack. Assumes the fetch unit presents the instruction at pc each cycle.
module warp_lane_ctrl
    import warp_pkg::*;
#(
    parameter int              LANES       = 32,
    parameter int              PC_W        = 16,
    parameter int              STACK_DEPTH = 8,
    parameter int              CNT_W       = 16,
    parameter logic [PC_W-1:0] START_PC    = '0,
    localparam int             DW          = $clog2(STACK_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [1:0]       instr_op,
    input  logic [LANES-1:0] lane_cond,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_reconv,
    output logic [LANES-1:0] lane_we,
    output logic [PC_W-1:0]  pc,
    output logic [LANES-1:0] active_mask,
    output logic [LANES-1:0] pred_mask,
    output logic [DW-1:0]    stack_depth,
    output logic [CNT_W-1:0] div_cycles,
    output logic             stack_err
);

    localparam logic [LANES-1:0] ALL_LANES = '1;

    logic [PC_W-1:0]  pc_q;
    logic [LANES-1:0] act_q;
    logic [LANES-1:0] pred_q;
    logic             err_q;

    warp_op_e         op;
    br_kind_e         kind;
    logic [LANES-1:0] take_lanes;
    logic [LANES-1:0] fall_lanes;
    logic [PC_W-1:0]  pc_inc;

    logic             at_merge;
    logic             exec;
    logic             push;
    logic             pop;
    logic             take_pend;

    logic [PC_W-1:0]  top_rcv;
    logic [PC_W-1:0]  top_pend_pc;
    logic [LANES-1:0] top_pend_mask;
    logic [LANES-1:0] top_save_mask;
    logic             top_pend_vld;
    logic             stk_empty;
    logic             stk_full;
    logic             stk_ovf;

    assign op        = warp_op_e'(instr_op);
    assign pc_inc    = pc_q + PC_W'(1);
    assign at_merge  = !stk_empty && (pc_q == top_rcv);
    assign exec      = instr_valid && !at_merge;
    assign push      = (kind == BR_SPLIT);
    assign take_pend = at_merge && top_pend_vld;
    assign pop       = at_merge && !top_pend_vld;

    warp_lane_enable #(
        .LANES (LANES)
    ) u_enable (
        .exec       (exec),
        .op         (op),
        .act        (act_q),
        .pred       (pred_q),
        .cond       (lane_cond),
        .we         (lane_we),
        .take_lanes (take_lanes),
        .fall_lanes (fall_lanes),
        .kind       (kind)
    );

    warp_reconv_stack #(
        .DEPTH (STACK_DEPTH),
        .LANES (LANES),
        .PC_W  (PC_W)
    ) u_stack (
        .clk           (clk),
        .rst_n         (rst_n),
        .push          (push),
        .pop           (pop),
        .take_pend     (take_pend),
        .in_rcv        (br_reconv),
        .in_pend_pc    (pc_inc),
        .in_pend_mask  (fall_lanes),
        .in_save_mask  (act_q),
        .top_rcv       (top_rcv),
        .top_pend_pc   (top_pend_pc),
        .top_pend_mask (top_pend_mask),
        .top_save_mask (top_save_mask),
        .top_pend_vld  (top_pend_vld),
        .depth         (stack_depth),
        .empty         (stk_empty),
        .full          (stk_full),
        .ovf           (stk_ovf)
    );

    warp_div_counter #(
        .W (CNT_W)
    ) u_divcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (exec && (act_q != ALL_LANES)),
        .count (div_cycles)
    );

    // Purpose: advance PC, mask and predicates for a switch cycle or an executed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= START_PC;
            act_q  <= ALL_LANES;
            pred_q <= '0;
        end else if (at_merge) begin
            if (top_pend_vld) begin
                pc_q  <= top_pend_pc;
                act_q <= top_pend_mask;
            end else begin
                act_q <= top_save_mask;
            end
        end else if (exec) begin
            unique case (op)
                OP_ALU, OP_PALU: pc_q <= pc_inc;
                OP_CMP: begin
                    pred_q <= (pred_q & ~act_q) | (lane_cond & act_q);
                    pc_q   <= pc_inc;
                end
                OP_BRA: begin
                    if (kind == BR_FALL) begin
                        pc_q <= pc_inc;
                    end else begin
                        pc_q <= br_target;
                    end
                    if (kind == BR_SPLIT) act_q <= take_lanes;
                end
                default: pc_q <= pc_inc;
            endcase
        end
    end

    // Purpose: latch a stack overflow until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (stk_ovf) err_q <= 1'b1;
    end

    assign pc          = pc_q;
    assign active_mask = act_q;
    assign pred_mask   = pred_q;
    assign stack_err   = err_q;

    // stk_full is consumed inside the stack through ovf; tied here for reference.
    logic unused_full;
    assign unused_full = stk_full;

endmodule

// File: rtl/warp_lane_ctrl_chk.sv
// Module: property checker for the warp sequencer, attached by bind.
// Observes ports only; assumes reset is held for at least two cycles.
module warp_lane_ctrl_chk #(
    parameter int LANES       = 32,
    parameter int PC_W        = 16,
    parameter int STACK_DEPTH = 8,
    parameter int CNT_W       = 16,
    localparam int DW         = $clog2(STACK_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [1:0]       instr_op,
    input logic [LANES-1:0] lane_cond,
    input logic [LANES-1:0] lane_we,
    input logic [PC_W-1:0]  pc,
    input logic [LANES-1:0] active_mask,
    input logic [LANES-1:0] pred_mask,
    input logic [DW-1:0]    stack_depth,
    input logic [CNT_W-1:0] div_cycles,
    input logic             stack_err
);

    p_we_in_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we & ~active_mask) == '0);

    p_cmp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_op == 2'b10) |-> lane_we == '0);

    p_palu_pred_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_op == 2'b01) |-> (lane_we & ~pred_mask) == '0);

    p_uniform_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_op == 2'b11 && stack_depth == '0 &&
         (lane_cond & active_mask) == active_mask)
        |=> active_mask == $past(active_mask));

    p_depth_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_depth == $past(stack_depth)) ||
        (stack_depth == $past(stack_depth) + DW'(1)) ||
        (stack_depth == $past(stack_depth) - DW'(1)));

    p_merged_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stack_err && stack_depth == '0) |-> active_mask == '1);

    p_cnt_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        div_cycles >= $past(div_cycles));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && stack_depth == '0)
        |=> (pc == $past(pc) && active_mask == $past(active_mask) &&
             pred_mask == $past(pred_mask)));

endmodule

bind warp_lane_ctrl warp_lane_ctrl_chk #(
    .LANES       (LANES),
    .PC_W        (PC_W),
    .STACK_DEPTH (STACK_DEPTH),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .lane_cond   (lane_cond),
    .lane_we     (lane_we),
    .pc          (pc),
    .active_mask (active_mask),
    .pred_mask   (pred_mask),
    .stack_depth (stack_depth),
    .div_cycles  (div_cycles),
    .stack_err   (stack_err)
);

// File: tb/tb_warp_lane_ctrl.sv
module tb_warp_lane_ctrl;

    localparam int LANES = 32;
    localparam int PC_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             instr_valid;
    logic [1:0]       instr_op;
    logic [LANES-1:0] lane_cond;
    logic [PC_W-1:0]  br_target;
    logic [PC_W-1:0]  br_reconv;
    logic [LANES-1:0] lane_we;
    logic [PC_W-1:0]  pc;
    logic [LANES-1:0] active_mask;
    logic [LANES-1:0] pred_mask;
    logic [3:0]       stack_depth;
    logic [15:0]      div_cycles;
    logic             stack_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    warp_lane_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_op    (instr_op),
        .lane_cond   (lane_cond),
        .br_target   (br_target),
        .br_reconv   (br_reconv),
        .lane_we     (lane_we),
        .pc          (pc),
        .active_mask (active_mask),
        .pred_mask   (pred_mask),
        .stack_depth (stack_depth),
        .div_cycles  (div_cycles),
        .stack_err   (stack_err)
    );

    typedef struct packed {
        logic        v;
        logic [1:0]  op;
        logic [31:0] cond;
        logic [15:0] tgt;
        logic [15:0] rcv;
        logic [31:0] we;
        logic [15:0] pc;
        logic [31:0] mask;
        logic [31:0] pred;
        logic [3:0]  depth;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    // Columns: valid, op, cond, target, merge | expected we now | pc, mask, pred, depth after | req
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'hFFFFFFFF, 16'h0001, 32'hFFFFFFFF, 32'h0,        4'd0, 4'd2},  // R2
        '{1'b1, 2'd2, 32'h0000FFFF, 16'h0,    16'h0,    32'h0,        16'h0002, 32'hFFFFFFFF, 32'h0000FFFF, 4'd0, 4'd3},  // R3
        '{1'b1, 2'd1, 32'h0,        16'h0,    16'h0,    32'h0000FFFF, 16'h0003, 32'hFFFFFFFF, 32'h0000FFFF, 4'd0, 4'd4},  // R4
        '{1'b1, 2'd3, 32'hFFFFFFFF, 16'h0020, 16'h0030, 32'h0,        16'h0020, 32'hFFFFFFFF, 32'h0000FFFF, 4'd0, 4'd5},  // R5 all take
        '{1'b1, 2'd3, 32'h0,        16'h0040, 16'h0030, 32'h0,        16'h0021, 32'hFFFFFFFF, 32'h0000FFFF, 4'd0, 4'd5},  // R5 none take
        '{1'b1, 2'd3, 32'h0000FFFF, 16'h0028, 16'h002C, 32'h0,        16'h0028, 32'h0000FFFF, 32'h0000FFFF, 4'd1, 4'd6},  // R6 split
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'h0000FFFF, 16'h0029, 32'h0000FFFF, 32'h0000FFFF, 4'd1, 4'd2},  // R2 partial
        '{1'b1, 2'd1, 32'h0,        16'h0,    16'h0,    32'h0000FFFF, 16'h002A, 32'h0000FFFF, 32'h0000FFFF, 4'd1, 4'd4},  // R4
        '{1'b1, 2'd2, 32'h00FF00FF, 16'h0,    16'h0,    32'h0,        16'h002B, 32'h0000FFFF, 32'h000000FF, 4'd1, 4'd3},  // R3 inactive keep
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'h0000FFFF, 16'h002C, 32'h0000FFFF, 32'h000000FF, 4'd1, 4'd2},  // R2
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'h0,        16'h0022, 32'hFFFF0000, 32'h000000FF, 4'd1, 4'd7},  // R7 switch
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'hFFFF0000, 16'h0023, 32'hFFFF0000, 32'h000000FF, 4'd1, 4'd2},  // R2
        '{1'b1, 2'd3, 32'hFF000000, 16'h0050, 16'h0024, 32'h0,        16'h0050, 32'hFF000000, 32'h000000FF, 4'd2, 4'd6},  // R6 nested
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'hFF000000, 16'h0051, 32'hFF000000, 32'h000000FF, 4'd2, 4'd2},  // R2
        '{1'b1, 2'd3, 32'hFFFFFFFF, 16'h0024, 16'h0,    32'h0,        16'h0024, 32'hFF000000, 32'h000000FF, 4'd2, 4'd5},  // R5
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'h0,        16'h0024, 32'h00FF0000, 32'h000000FF, 4'd2, 4'd7},  // R7
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'h0,        16'h0024, 32'hFFFF0000, 32'h000000FF, 4'd1, 4'd8},  // R8 pop
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'hFFFF0000, 16'h0025, 32'hFFFF0000, 32'h000000FF, 4'd1, 4'd2},  // R2
        '{1'b1, 2'd3, 32'hFFFF0000, 16'h002C, 16'h0,    32'h0,        16'h002C, 32'hFFFF0000, 32'h000000FF, 4'd1, 4'd5},  // R5 inactive ignored
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'h0,        16'h002C, 32'hFFFFFFFF, 32'h000000FF, 4'd0, 4'd8},  // R8 pop
        '{1'b1, 2'd0, 32'h0,        16'h0,    16'h0,    32'hFFFFFFFF, 16'h002D, 32'hFFFFFFFF, 32'h000000FF, 4'd0, 4'd2},  // R2
        '{1'b0, 2'd0, 32'h0,        16'h0,    16'h0,    32'h0,        16'h002D, 32'hFFFFFFFF, 32'h000000FF, 4'd0, 4'd11}  // R11
    };

    task automatic chk(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [31:0] c,
                         input logic [15:0] t, input logic [15:0] r);
        instr_valid = v;
        instr_op    = op;
        lane_cond   = c;
        br_target   = t;
        br_reconv   = r;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(1'b0, 2'd0, 32'h0, 16'h0, 16'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_reset_state();
        // R1: reset values
        chk(1, "pc", 32'(pc), 32'h0);
        chk(1, "mask", active_mask, 32'hFFFFFFFF);
        chk(1, "pred", pred_mask, 32'h0);
        chk(1, "depth", 32'(stack_depth), 32'h0);
        chk(1, "err", 32'(stack_err), 32'h0);
        chk(1, "count", 32'(div_cycles), 32'h0);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        check_reset_state();
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].v, TBL[i].op, TBL[i].cond, TBL[i].tgt, TBL[i].rcv);
            #1;
            chk(int'(TBL[i].req), $sformatf("we step %0d", i), lane_we, TBL[i].we);
            @(posedge clk);
            @(negedge clk);
            chk(int'(TBL[i].req), $sformatf("pc step %0d", i), 32'(pc), 32'(TBL[i].pc));
            chk(int'(TBL[i].req), $sformatf("mask step %0d", i), active_mask, TBL[i].mask);
            chk(int'(TBL[i].req), $sformatf("pred step %0d", i), pred_mask, TBL[i].pred);
            chk(int'(TBL[i].req), $sformatf("depth step %0d", i), 32'(stack_depth), 32'(TBL[i].depth));
        end
        // R9: ten executed cycles ran with a partial mask in the program above
        chk(9, "partial count", 32'(div_cycles), 32'd10);

        // R10: nine nested splits against an eight-entry stack
        do_reset();
        rst_n = 1'b1;
        for (int i = 0; i < 9; i++) begin
            drive(1'b1, 2'd3, 32'hFFFFFFFF >> (i + 1), 16'h0100 + 16'(i), 16'hFFFF);
            @(posedge clk);
            @(negedge clk);
            if (i == 7) begin
                chk(10, "depth at full", 32'(stack_depth), 32'd8);
                chk(10, "err before overflow", 32'(stack_err), 32'd0);
            end
        end
        chk(10, "err after overflow", 32'(stack_err), 32'd1);
        chk(10, "depth after overflow", 32'(stack_depth), 32'd8);
        chk(10, "mask after overflow", active_mask, 32'hFFFFFFFF >> 9);
        chk(10, "pc after overflow", 32'(pc), 32'h0108);
        drive(1'b0, 2'd0, 32'h0, 16'h0, 16'h0);
        @(posedge clk);
        @(negedge clk);
        chk(10, "err held", 32'(stack_err), 32'd1);

        // R1: mid-run reset restores every state
        do_reset();
        check_reset_state();
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule